// File: doc/BRIEF.md
# Scoreboard Issue and Completion Controller

This block is the control half of a dynamically scheduled floating-point pipeline that keeps no operand values. Decoded instructions arrive one at a time, in program order. Each carries an operation class, a destination register number and two source register numbers. There are four execution units: load, add/subtract, multiply and divide. Each unit holds one operation at a time and is not pipelined. The controller keeps a per-unit record of the operation in flight. It also keeps a per-register note of which unit will next write that register.

Each instruction goes through four steps, and the controller emits a one-cycle event for each: accepted (issue), operands read, execution finished, result written. Execution is modelled only by a countdown of the unit's latency. A register entry holds a unit number, never a value, so a later writer of a register cannot be given a fresh copy of it. Both write-after-write and write-after-read conflicts therefore hold instructions back instead of being renamed away.

Operation class encoding: 0 = load, 1 = add/subtract, 2 = multiply, 3 = divide. Bit `k` of each event vector belongs to the unit of class `k`.

Top module: `sb_ctrl`

## Requirements
- R1: While reset is held, `in_ready` is 1 and all four event vectors are 0.
- R2: `in_ready` is 0 whenever the unit of `in_op` is holding an operation. That holds from the cycle it is accepted through the cycle its result is written. `iss_evt` is 1 exactly when `in_valid` and `in_ready` are both 1, so at most one instruction is accepted per cycle and the next one waits behind a stalled one.
- R3: `in_ready` is 0 while any in-flight instruction has a destination equal to `in_dst`.
- R4: An accepted instruction reads its operands (`rd_evt` bit) at the earliest in the cycle after acceptance. It reads only once neither source register has a pending writer other than the ones that had already written when it was accepted.
- R5: The unit's `cmp_evt` bit pulses exactly LAT cycles after its `rd_evt` bit. LAT is 2 for load, 5 for add/subtract, 10 for multiply and 20 for divide.
- R6: The `wr_evt` bit pulses at the earliest in the cycle after `cmp_evt`.
- R7: A unit's result write is held while another accepted instruction that has not yet read its operands names the same register as a source and treats that source as already available.
- R8: A result write frees both the unit and the destination register. A waiting instruction may then be accepted, or may read a source it was waiting for, in the very next cycle, and not in the write cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A decoded instruction is offered |
| in_op | input | 2 | Operation class (0 load, 1 add/sub, 2 multiply, 3 divide) |
| in_dst | input | REG_W | Destination register number |
| in_src1 | input | REG_W | First source register number |
| in_src2 | input | REG_W | Second source register number |
| in_ready | output | 1 | The offered instruction can be accepted this cycle |
| iss_evt | output | 1 | Instruction accepted this cycle |
| rd_evt | output | 4 | Per-unit operand-read event |
| cmp_evt | output | 4 | Per-unit execution-finished event |
| wr_evt | output | 4 | Per-unit result-write event |

## Verification
Any corrupted internal state shows up at the ports within a few cycles. A wrong register-writer entry either drops `in_ready` in the very cycle a free destination is offered, or moves a later `rd_evt` edge earlier or later. A stuck countdown shifts `cmp_evt` and then `wr_evt` away from the expected latency. A missed read-after-write dependency brings `rd_evt` forward in the cycle after acceptance. A missed write-after-read check lets `wr_evt` fire before the pending reader's `rd_evt`. Every such deviation changes the cycle of some pulse, so comparing all outputs on every cycle against an independent schedule model catches it at the first cycle it happens.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int NU = 4;
    localparam int UW = 2;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_ADD  = 2'd1,
        OP_MUL  = 2'd2,
        OP_DIV  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_EXEC  = 2'd2,
        ST_WRITE = 2'd3
    } ust_e;
endpackage

// File: rtl/sb_regstat.sv
module sb_regstat
    import sb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int REG_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic [REG_W-1:0] set_reg_i,
    input  logic [UW-1:0]    set_unit_i,
    input  logic [NU-1:0]    wr_all_i,
    input  logic [REG_W-1:0] s1_reg_i,
    input  logic [REG_W-1:0] s2_reg_i,
    input  logic [REG_W-1:0] dst_reg_i,
    output logic             s1_pend_o,
    output logic [UW-1:0]    s1_unit_o,
    output logic             s2_pend_o,
    output logic [UW-1:0]    s2_unit_o,
    output logic             dst_pend_o
);
    typedef struct packed {
        logic          pend;
        logic [UW-1:0] unit;
    } rs_ent_t;

    rs_ent_t tab_d [NUM_REGS];
    rs_ent_t tab_q [NUM_REGS];

    always_comb begin
        for (int r = 0; r < NUM_REGS; r++) begin
            tab_d[r] = tab_q[r];
            if (tab_q[r].pend && wr_all_i[tab_q[r].unit]) begin
                tab_d[r].pend = 1'b0;
            end
            if (set_i && (set_reg_i == REG_W'(r))) begin
                tab_d[r].pend = 1'b1;
                tab_d[r].unit = set_unit_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int r = 0; r < NUM_REGS; r++) begin
            if (!rst_n) tab_q[r] <= '0;
            else        tab_q[r] <= tab_d[r];
        end
    end

    assign s1_pend_o  = tab_q[s1_reg_i].pend;
    assign s1_unit_o  = tab_q[s1_reg_i].unit;
    assign s2_pend_o  = tab_q[s2_reg_i].pend;
    assign s2_unit_o  = tab_q[s2_reg_i].unit;
    assign dst_pend_o = tab_q[dst_reg_i].pend;

    // R3: a new writer is never recorded over a pending one
    assert_no_double_writer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |-> !tab_q[set_reg_i].pend);
endmodule

// File: rtl/sb_unit.sv
module sb_unit
    import sb_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int LAT   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_i,
    input  logic [REG_W-1:0] iss_dst_i,
    input  logic [REG_W-1:0] iss_s1_i,
    input  logic [REG_W-1:0] iss_s2_i,
    input  logic [UW-1:0]    iss_q1_i,
    input  logic [UW-1:0]    iss_q2_i,
    input  logic             iss_r1_i,
    input  logic             iss_r2_i,
    input  logic [NU-1:0]    wr_all_i,
    input  logic             war_hold_i,
    output logic             busy_o,
    output logic             pend_read_o,
    output logic [REG_W-1:0] dst_o,
    output logic [REG_W-1:0] s1_o,
    output logic [REG_W-1:0] s2_o,
    output logic             r1_o,
    output logic             r2_o,
    output logic             rd_o,
    output logic             cmp_o,
    output logic             wr_o
);
    localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1;
    localparam int AGE_W = $clog2(LAT + 1) + 1;

    typedef struct packed {
        ust_e             st;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] s1;
        logic [REG_W-1:0] s2;
        logic [UW-1:0]    q1;
        logic [UW-1:0]    q2;
        logic             r1;
        logic             r2;
        logic [CNT_W-1:0] cnt;
    } ustate_t;

    ustate_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        rd_o  = (s_q.st == ST_READ) && s_q.r1 && s_q.r2;
        cmp_o = (s_q.st == ST_EXEC) && (s_q.cnt == '0);
        wr_o  = (s_q.st == ST_WRITE) && !war_hold_i;
        if (!s_q.r1 && wr_all_i[s_q.q1]) s_d.r1 = 1'b1;
        if (!s_q.r2 && wr_all_i[s_q.q2]) s_d.r2 = 1'b1;
        case (s_q.st)
            ST_IDLE: begin
                if (iss_i) begin
                    s_d.st  = ST_READ;
                    s_d.dst = iss_dst_i;
                    s_d.s1  = iss_s1_i;
                    s_d.s2  = iss_s2_i;
                    s_d.q1  = iss_q1_i;
                    s_d.q2  = iss_q2_i;
                    s_d.r1  = iss_r1_i;
                    s_d.r2  = iss_r2_i;
                end
            end
            ST_READ: begin
                if (rd_o) begin
                    s_d.st  = ST_EXEC;
                    s_d.cnt = CNT_W'(LAT - 1);
                end
            end
            ST_EXEC: begin
                if (cmp_o) s_d.st  = ST_WRITE;
                else       s_d.cnt = s_q.cnt - 1'b1;
            end
            ST_WRITE: begin
                if (wr_o) s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o      = (s_q.st != ST_IDLE);
    assign pend_read_o = (s_q.st == ST_READ);
    assign dst_o       = s_q.dst;
    assign s1_o        = s_q.s1;
    assign s2_o        = s_q.s2;
    assign r1_o        = s_q.r1;
    assign r2_o        = s_q.r2;

    // independent up-counter of execute cycles, used only by the latency check
    logic [AGE_W-1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                          age_q <= '0;
        else if (rd_o)                       age_q <= AGE_W'(1);
        else if (s_q.st == ST_EXEC && !cmp_o) age_q <= age_q + 1'b1;
    end

    // R2: the top only hands an instruction to an empty unit
    assert_issue_to_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        iss_i |-> (s_q.st == ST_IDLE));

    // R5: execution finishes after exactly LAT cycles
    assert_exec_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_o |-> (age_q == AGE_W'(LAT)));
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
    import sb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int LAT_LOAD = 2,
    parameter int LAT_ADD  = 5,
    parameter int LAT_MUL  = 10,
    parameter int LAT_DIV  = 20,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [UW-1:0]    in_op,
    input  logic [REG_W-1:0] in_dst,
    input  logic [REG_W-1:0] in_src1,
    input  logic [REG_W-1:0] in_src2,
    output logic             in_ready,
    output logic             iss_evt,
    output logic [NU-1:0]    rd_evt,
    output logic [NU-1:0]    cmp_evt,
    output logic [NU-1:0]    wr_evt
);
    logic [NU-1:0]    u_busy, u_pend_read, u_r1, u_r2, u_hold, iss_vec;
    logic [REG_W-1:0] u_dst [NU];
    logic [REG_W-1:0] u_s1  [NU];
    logic [REG_W-1:0] u_s2  [NU];

    logic             s1_pend, s2_pend, dst_pend;
    logic [UW-1:0]    s1_unit, s2_unit;
    logic             iss_r1, iss_r2;

    assign in_ready = !u_busy[in_op] && !dst_pend;
    assign iss_evt  = in_valid && in_ready;
    assign iss_r1   = !s1_pend || wr_evt[s1_unit];
    assign iss_r2   = !s2_pend || wr_evt[s2_unit];

    always_comb begin
        for (int u = 0; u < NU; u++) begin
            iss_vec[u] = iss_evt && (in_op == UW'(u));
        end
    end

    // write-after-read guard across the units
    always_comb begin
        u_hold = '0;
        for (int u = 0; u < NU; u++) begin
            for (int f = 0; f < NU; f++) begin
                if (f != u && u_pend_read[f] &&
                    ((u_s1[f] == u_dst[u] && u_r1[f]) ||
                     (u_s2[f] == u_dst[u] && u_r2[f]))) begin
                    u_hold[u] = 1'b1;
                end
            end
        end
    end

    sb_regstat #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W)
    ) u_regstat (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (iss_evt),
        .set_reg_i  (in_dst),
        .set_unit_i (in_op),
        .wr_all_i   (wr_evt),
        .s1_reg_i   (in_src1),
        .s2_reg_i   (in_src2),
        .dst_reg_i  (in_dst),
        .s1_pend_o  (s1_pend),
        .s1_unit_o  (s1_unit),
        .s2_pend_o  (s2_pend),
        .s2_unit_o  (s2_unit),
        .dst_pend_o (dst_pend)
    );

    for (genvar g = 0; g < NU; g++) begin : g_unit
        localparam int LAT_G = (g == 0) ? LAT_LOAD :
                               (g == 1) ? LAT_ADD  :
                               (g == 2) ? LAT_MUL  : LAT_DIV;
        sb_unit #(
            .REG_W (REG_W),
            .LAT   (LAT_G)
        ) u_fu (
            .clk         (clk),
            .rst_n       (rst_n),
            .iss_i       (iss_vec[g]),
            .iss_dst_i   (in_dst),
            .iss_s1_i    (in_src1),
            .iss_s2_i    (in_src2),
            .iss_q1_i    (s1_unit),
            .iss_q2_i    (s2_unit),
            .iss_r1_i    (iss_r1),
            .iss_r2_i    (iss_r2),
            .wr_all_i    (wr_evt),
            .war_hold_i  (u_hold[g]),
            .busy_o      (u_busy[g]),
            .pend_read_o (u_pend_read[g]),
            .dst_o       (u_dst[g]),
            .s1_o        (u_s1[g]),
            .s2_o        (u_s2[g]),
            .r1_o        (u_r1[g]),
            .r2_o        (u_r2[g]),
            .rd_o        (rd_evt[g]),
            .cmp_o       (cmp_evt[g]),
            .wr_o        (wr_evt[g])
        );
    end

    // R4: an accepted instruction is waiting for its operand read in the next cycle
    assert_read_after_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
        iss_evt |=> (($past(iss_vec) & u_pend_read) != '0));
endmodule

// File: tb/sim_sb_ctrl.sv
`timescale 1ns/1ps
module sim_sb_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] in_op = '0;
    logic [4:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic       in_ready, iss_evt;
    logic [3:0] rd_evt, cmp_evt, wr_evt;

    always #5 clk = ~clk;

    sb_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .in_ready(in_ready), .iss_evt(iss_evt),
        .rd_evt(rd_evt), .cmp_evt(cmp_evt), .wr_evt(wr_evt)
    );

    int errors = 0, checks = 0, cyc = 0;
    bit done = 0;

    // program under test
    int p_op[$], p_d[$], p_s1[$], p_s2[$];
    int pc = 0;
    int base = -1;
    int r_iss[16], r_rd[16], r_cmp[16], r_wr[16];
    int unit_ins[4];

    // behavioural schedule model
    int m_stage[4];              // 0 free, 1 waiting read, 2 executing, 3 waiting write
    int m_dst[4], m_s1[4], m_s2[4], m_q1[4], m_q2[4], m_rem[4];
    int m_rs[32];                // producing unit, -1 when none

    function automatic int lat(int u);
        case (u)
            0: return 2;
            1: return 5;
            2: return 10;
            default: return 20;
        endcase
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    task automatic add_ins(int op, int d, int s1, int s2);
        p_op.push_back(op); p_d.push_back(d); p_s1.push_back(s1); p_s2.push_back(s2);
    endtask

    function automatic bit model_idle();
        for (int u = 0; u < 4; u++) if (m_stage[u] != 0) return 0;
        return 1;
    endfunction

    task automatic one_cycle();
        int op, d, s1, s2;
        bit e_ready, e_iss;
        bit [3:0] e_rd, e_cmp, e_wr;
        int rs_old[32];
        @(negedge clk);
        if (pc < p_op.size()) begin
            in_valid = 1; op = p_op[pc]; d = p_d[pc]; s1 = p_s1[pc]; s2 = p_s2[pc];
        end else begin
            in_valid = 0; op = 0; d = 0; s1 = 0; s2 = 0;
        end
        in_op = 2'(op); in_dst = 5'(d); in_src1 = 5'(s1); in_src2 = 5'(s2);
        #2;
        e_ready = (m_stage[op] == 0) && (m_rs[d] < 0);
        e_iss   = in_valid && e_ready;
        for (int u = 0; u < 4; u++) begin
            bit hold = 0;
            e_rd[u]  = (m_stage[u] == 1) && (m_q1[u] < 0) && (m_q2[u] < 0);
            e_cmp[u] = (m_stage[u] == 2) && (m_rem[u] == 0);
            for (int f = 0; f < 4; f++)
                if (f != u && m_stage[f] == 1 &&
                    ((m_s1[f] == m_dst[u] && m_q1[f] < 0) || (m_s2[f] == m_dst[u] && m_q2[f] < 0)))
                    hold = 1;
            e_wr[u] = (m_stage[u] == 3) && !hold;
        end
        // R2 R3: acceptance; R4 read; R5 finish; R6 R7 write
        chk(in_ready == e_ready, "R2/R3 in_ready", in_ready, e_ready);
        chk(iss_evt == e_iss, "R2 iss_evt", iss_evt, e_iss);
        chk(rd_evt == e_rd, "R4 rd_evt", rd_evt, e_rd);
        chk(cmp_evt == e_cmp, "R5 cmp_evt", cmp_evt, e_cmp);
        chk(wr_evt == e_wr, "R6/R7 wr_evt", wr_evt, e_wr);
        // record event cycles from the outputs
        if (iss_evt) begin
            if (base < 0) base = cyc;
            unit_ins[op] = pc;
            r_iss[pc] = cyc - base + 1;
        end
        for (int u = 0; u < 4; u++) begin
            if (rd_evt[u])  r_rd[unit_ins[u]]  = cyc - base + 1;
            if (cmp_evt[u]) r_cmp[unit_ins[u]] = cyc - base + 1;
            if (wr_evt[u])  r_wr[unit_ins[u]]  = cyc - base + 1;
        end
        // advance the model
        for (int r = 0; r < 32; r++) rs_old[r] = m_rs[r];
        for (int u = 0; u < 4; u++) begin
            if (e_wr[u]) begin
                m_stage[u] = 0;
                for (int r = 0; r < 32; r++) if (m_rs[r] == u) m_rs[r] = -1;
                for (int f = 0; f < 4; f++) begin
                    if (m_q1[f] == u) m_q1[f] = -1;
                    if (m_q2[f] == u) m_q2[f] = -1;
                end
            end else if (e_rd[u]) begin
                m_stage[u] = 2; m_rem[u] = lat(u) - 1;
            end else if (e_cmp[u]) begin
                m_stage[u] = 3;
            end else if (m_stage[u] == 2) begin
                m_rem[u]--;
            end
        end
        if (e_iss) begin
            m_stage[op] = 1; m_dst[op] = d; m_s1[op] = s1; m_s2[op] = s2;
            m_q1[op] = (rs_old[s1] >= 0 && !e_wr[rs_old[s1]]) ? rs_old[s1] : -1;
            m_q2[op] = (rs_old[s2] >= 0 && !e_wr[rs_old[s2]]) ? rs_old[s2] : -1;
            m_rs[d] = op;
            pc++;
        end
        cyc++;
    endtask

    task automatic run_prog();
        int guard = 0;
        pc = 0; base = -1;
        for (int i = 0; i < 16; i++) begin r_iss[i] = 0; r_rd[i] = 0; r_cmp[i] = 0; r_wr[i] = 0; end
        do begin
            one_cycle();
            guard++;
        end while ((pc < p_op.size() || !model_idle()) && guard < 1000);
        repeat (2) one_cycle();
    endtask

    task automatic exp_ev(int i, int ei, int er, int ec, int ew, string tag);
        chk(r_iss[i] == ei, {tag, " issue cycle"}, r_iss[i], ei);
        chk(r_rd[i]  == er, {tag, " read cycle"},  r_rd[i],  er);
        chk(r_cmp[i] == ec, {tag, " finish cycle"}, r_cmp[i], ec);
        chk(r_wr[i]  == ew, {tag, " write cycle"}, r_wr[i],  ew);
    endtask

    task automatic clear_prog();
        p_op.delete(); p_d.delete(); p_s1.delete(); p_s2.delete();
    endtask

    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 20000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int u = 0; u < 4; u++) begin
            m_stage[u] = 0; m_q1[u] = -1; m_q2[u] = -1; m_dst[u] = 0;
            m_s1[u] = 0; m_s2[u] = 0; m_rem[u] = 0; unit_ins[u] = 0;
        end
        for (int r = 0; r < 32; r++) m_rs[r] = -1;

        // R1: reset state
        repeat (3) begin
            @(negedge clk); #2;
            chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
            chk({rd_evt, cmp_evt, wr_evt} == '0, "R1 events", {rd_evt, cmp_evt, wr_evt}, 0);
        end
        @(negedge clk); rst_n = 1;

        // A: loads, WAW stall, RAW waits, structural stall (R2 R3 R4 R5 R6 R8)
        add_ins(0, 2, 31, 31);
        add_ins(0, 4, 31, 31);
        add_ins(1, 4, 12, 10);
        add_ins(2, 12, 2, 4);
        add_ins(1, 8, 8, 4);
        add_ins(3, 4, 2, 12);
        run_prog();
        exp_ev(0, 1, 2, 4, 5, "R5 load1");
        exp_ev(1, 6, 7, 9, 10, "R2/R8 load2");
        exp_ev(2, 11, 12, 17, 18, "R3 add");
        exp_ev(3, 12, 19, 29, 30, "R4 mul");
        exp_ev(4, 19, 20, 25, 26, "R2 sub");
        exp_ev(5, 20, 31, 51, 52, "R4/R6 div");

        // B: write-after-read hold (R7)
        clear_prog();
        add_ins(3, 0, 2, 4);
        add_ins(1, 6, 0, 8);
        add_ins(0, 8, 31, 31);
        run_prog();
        exp_ev(0, 1, 2, 22, 23, "R5 div");
        exp_ev(1, 2, 24, 29, 30, "R8 add");
        exp_ev(2, 3, 4, 6, 25, "R7 load");

        // C: mixed chain, compared against the model only
        clear_prog();
        add_ins(0, 1, 31, 31);
        add_ins(1, 3, 1, 1);
        add_ins(2, 5, 3, 1);
        add_ins(3, 7, 5, 3);
        add_ins(0, 9, 31, 31);
        add_ins(1, 1, 9, 7);
        add_ins(2, 3, 1, 9);
        add_ins(0, 5, 31, 31);
        run_prog();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule